// File: doc/BRIEF.md
# Byte-lane I/O window decoder

This block sits between a byte-addressable host I/O window of 128 bytes and three groups of register targets that only accept whole 32-bit words. The host may read or write 1, 2, 3 or 4 bytes starting at any byte offset. The block decodes the word address into one of three regions: a bank of protocol-core registers, a bank of DMA-channel registers and a single bus-control word. Each target exposes a word index, a combinational read word, a write strobe and a write word.

Reads fetch the aligned word from the selected target, shift it down by the byte offset and keep only the requested number of bytes. The result comes back one cycle later with a response valid flag. Writes never reach a target as partial data. The block reads the target's current word in the same cycle and replaces only the addressed byte lanes. It then issues a single full-word write strobe to that one target. Offsets that decode to no region read as zero and drop writes.

Top module: `io_window_dec`

## Requirements
- R1: Byte offsets 0x00 to 0x3F select the core bank, and the word index on core_idx_o is addr[5:2].
- R2: Byte offsets 0x40 to 0x5F select the DMA bank, and the word index on dma_idx_o is (addr - 0x40) >> 2.
- R3: The word at offsets 0x70 to 0x73 is the bus-control target. Decoding uses addr[6:2] for both reads and writes.
- R4: Offsets 0x60 to 0x6F and 0x74 to 0x7F are unmapped. A read there returns 0, and a write there raises no write strobe, so no target word changes.
- R5: Read data equals the aligned target word shifted right by 8 x addr[1:0], with every bit at position 8 x size and above forced to 0.
- R6: On a write, byte i of req_wdata_i (bits 8i+7:8i, for i < size) goes to lane addr[1:0] + i of the target word when that lane is below 4. Bytes that would fall past lane 3 are dropped, and every other lane keeps the target's current value.
- R7: A write to a mapped offset raises the write strobe of exactly that one target, in the same cycle as req_valid_i. The strobe carries the full merged 32-bit word, and no strobe is ever raised without a valid write.
- R8: A read accepted in cycle n gives rsp_valid_o = 1 and rsp_rdata_o in cycle n+1. A cycle with no read gives rsp_valid_o = 0 in the next cycle. After reset both outputs are 0.
- R9: req_size_i encodes the byte count directly: 1, 2, 3 or 4. The data is little-endian, so the byte at the lowest address is held in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Byte offset in the window |
| req_size_i | input | 3 | Byte count, 1 to 4 |
| req_wdata_i | input | 32 | Write bytes, least significant first |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| core_idx_o | output | 4 | Core bank word index |
| core_rdata_i | input | 32 | Current core word at core_idx_o |
| core_we_o | output | 1 | Core word write strobe |
| core_wdata_o | output | 32 | Core write word |
| dma_idx_o | output | 3 | DMA bank word index |
| dma_rdata_i | input | 32 | Current DMA word at dma_idx_o |
| dma_we_o | output | 1 | DMA word write strobe |
| dma_wdata_o | output | 32 | DMA write word |
| ctl_rdata_i | input | 32 | Current bus-control word |
| ctl_we_o | output | 1 | Bus-control write strobe |
| ctl_wdata_o | output | 32 | Bus-control write word |

## Verification
The assertions assume that every valid request carries a size from 1 to 4. They also assume that each target returns, in the same cycle, the word at the index it is given, because the merge reads that word to rebuild untouched lanes. The stimulus drives only legal sizes and models each target as an array read combinationally at the block's index output. It sweeps every byte offset of the window with every size, once for writes and once for reads, so misaligned spills past lane 3 and all unmapped holes are covered.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CORE = 2'd1,
    RGN_DMA  = 2'd2,
    RGN_CTL  = 2'd3
  } region_e;
endpackage

// File: rtl/io_win_decode.sv
module io_win_decode
  import io_win_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CORE_BASE  = 'h00,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int CTL_ADDR   = 'h70,
  localparam int WA_W      = ADDR_W - 2,
  localparam int CORE_IW   = $clog2(CORE_WORDS),
  localparam int DMA_IW    = $clog2(DMA_WORDS)
) (
  input  logic [WA_W-1:0]    word_addr_i,
  output region_e            region_o,
  output logic [CORE_IW-1:0] core_idx_o,
  output logic [DMA_IW-1:0]  dma_idx_o
);
  localparam logic [WA_W-1:0] CORE_WA = WA_W'(CORE_BASE / 4);
  localparam logic [WA_W-1:0] DMA_WA  = WA_W'(DMA_BASE / 4);
  localparam logic [WA_W-1:0] CTL_WA  = WA_W'(CTL_ADDR / 4);
  localparam logic [WA_W:0]   CORE_END = (WA_W+1)'(CORE_BASE / 4 + CORE_WORDS);
  localparam logic [WA_W:0]   DMA_END  = (WA_W+1)'(DMA_BASE / 4 + DMA_WORDS);

  logic [WA_W-1:0] core_off, dma_off;
  logic            in_core, in_dma;

  assign core_off = word_addr_i - CORE_WA;
  assign dma_off  = word_addr_i - DMA_WA;
  assign in_core  = (word_addr_i >= CORE_WA) && ({1'b0, word_addr_i} < CORE_END);
  assign in_dma   = (word_addr_i >= DMA_WA) && ({1'b0, word_addr_i} < DMA_END);

  assign core_idx_o = core_off[CORE_IW-1:0];
  assign dma_idx_o  = dma_off[DMA_IW-1:0];

  always_comb begin
    if (in_core)                    region_o = RGN_CORE;
    else if (in_dma)                region_o = RGN_DMA;
    else if (word_addr_i == CTL_WA) region_o = RGN_CTL;
    else                            region_o = RGN_NONE;
  end
endmodule

// File: rtl/io_win_merge.sv
module io_win_merge #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int LANE_W = $clog2(NB),
  localparam int SIZE_W = LANE_W + 1
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANE_W-1:0] off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] wsh;
  assign wsh = wdata_i << {off_i, 3'b000};

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic hit;
    assign hit = (l >= int'(off_i)) && (l < int'(off_i) + int'(size_i));
    assign merged_o[l*8 +: 8] = hit ? wsh[l*8 +: 8] : cur_i[l*8 +: 8];
  end
endmodule

// File: rtl/io_win_extract.sv
module io_win_extract #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int LANE_W = $clog2(NB),
  localparam int SIZE_W = LANE_W + 1
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LANE_W-1:0] off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shifted;
  assign shifted = word_i >> {off_i, 3'b000};

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign data_o[l*8 +: 8] = (l < int'(size_i)) ? shifted[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/io_window_dec.sv
module io_window_dec
  import io_win_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CORE_BASE  = 'h00,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int CTL_ADDR   = 'h70,
  localparam int NB        = DATA_W / 8,
  localparam int LANE_W    = $clog2(NB),
  localparam int SIZE_W    = LANE_W + 1,
  localparam int CORE_IW   = $clog2(CORE_WORDS),
  localparam int DMA_IW    = $clog2(DMA_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [SIZE_W-1:0]  req_size_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic [CORE_IW-1:0] core_idx_o,
  input  logic [DATA_W-1:0]  core_rdata_i,
  output logic               core_we_o,
  output logic [DATA_W-1:0]  core_wdata_o,
  output logic [DMA_IW-1:0]  dma_idx_o,
  input  logic [DATA_W-1:0]  dma_rdata_i,
  output logic               dma_we_o,
  output logic [DATA_W-1:0]  dma_wdata_o,
  input  logic [DATA_W-1:0]  ctl_rdata_i,
  output logic               ctl_we_o,
  output logic [DATA_W-1:0]  ctl_wdata_o
);
  region_e           region;
  logic [DATA_W-1:0] cur_word, merged, rd_data;
  logic [LANE_W-1:0] off;
  logic              wr_go, rd_go;

  assign off   = req_addr_i[LANE_W-1:0];
  assign wr_go = req_valid_i && req_write_i;
  assign rd_go = req_valid_i && !req_write_i;

  io_win_decode #(
    .ADDR_W(ADDR_W), .CORE_BASE(CORE_BASE), .CORE_WORDS(CORE_WORDS),
    .DMA_BASE(DMA_BASE), .DMA_WORDS(DMA_WORDS), .CTL_ADDR(CTL_ADDR)
  ) u_decode (
    .word_addr_i (req_addr_i[ADDR_W-1:2]),
    .region_o    (region),
    .core_idx_o  (core_idx_o),
    .dma_idx_o   (dma_idx_o)
  );

  always_comb begin
    unique case (region)
      RGN_CORE: cur_word = core_rdata_i;
      RGN_DMA:  cur_word = dma_rdata_i;
      RGN_CTL:  cur_word = ctl_rdata_i;
      default:  cur_word = '0;
    endcase
  end

  io_win_merge #(.DATA_W(DATA_W)) u_merge (
    .cur_i    (cur_word),
    .wdata_i  (req_wdata_i),
    .off_i    (off),
    .size_i   (req_size_i),
    .merged_o (merged)
  );

  io_win_extract #(.DATA_W(DATA_W)) u_extract (
    .word_i (cur_word),
    .off_i  (off),
    .size_i (req_size_i),
    .data_o (rd_data)
  );

  assign core_we_o    = wr_go && (region == RGN_CORE);
  assign dma_we_o     = wr_go && (region == RGN_DMA);
  assign ctl_we_o     = wr_go && (region == RGN_CTL);
  assign core_wdata_o = merged;
  assign dma_wdata_o  = merged;
  assign ctl_wdata_o  = merged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_go;
      if (rd_go) rsp_rdata_o <= rd_data;
    end
  end

  // input contract: legal byte count
  p_size_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_size_i >= SIZE_W'(1) && req_size_i <= SIZE_W'(NB)));

  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_we_o, dma_we_o, ctl_we_o}));

  p_strobe_needs_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_we_o || dma_we_o || ctl_we_o) |-> (req_valid_i && req_write_i));

  p_rsp_follows_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  p_no_spurious_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

  p_unmapped_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && region == RGN_NONE) |=> (rsp_rdata_o == '0));

  // lanes below the offset are never overwritten
  p_low_lanes_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_we_o && off != '0) |-> (core_wdata_o[7:0] == core_rdata_i[7:0]));
endmodule

// File: tb/io_window_dec_tb_top.sv
`timescale 1ns/1ps
module io_window_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  core_idx;
  logic [2:0]  dma_idx;
  logic        core_we, dma_we, ctl_we;
  logic [31:0] core_wdata, dma_wdata, ctl_wdata;
  logic [31:0] m_core [16];
  logic [31:0] m_dma  [8];
  logic [31:0] m_ctl;
  logic [31:0] sh_core [16];
  logic [31:0] sh_dma  [8];
  logic [31:0] sh_ctl;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  io_window_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .core_idx_o(core_idx), .core_rdata_i(m_core[core_idx]),
    .core_we_o(core_we), .core_wdata_o(core_wdata),
    .dma_idx_o(dma_idx), .dma_rdata_i(m_dma[dma_idx]),
    .dma_we_o(dma_we), .dma_wdata_o(dma_wdata),
    .ctl_rdata_i(m_ctl), .ctl_we_o(ctl_we), .ctl_wdata_o(ctl_wdata)
  );

  always @(posedge clk) begin
    if (core_we) m_core[core_idx] <= core_wdata;
    if (dma_we)  m_dma[dma_idx]   <= dma_wdata;
    if (ctl_we)  m_ctl            <= ctl_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // 0 none, 1 core, 2 dma, 3 ctl
  function automatic int tgt_of(input int a);
    if (a < 'h40) return 1;
    if (a < 'h60) return 2;
    if ((a >> 2) == ('h70 >> 2)) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] sh_word(input int a);
    case (tgt_of(a))
      1: return sh_core[a >> 2];
      2: return sh_dma[(a - 'h40) >> 2];
      3: return sh_ctl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic sh_store(input int a, input logic [31:0] w);
    case (tgt_of(a))
      1: sh_core[a >> 2] = w;
      2: sh_dma[(a - 'h40) >> 2] = w;
      3: sh_ctl = w;
      default: ;
    endcase
  endtask

  task automatic do_write(input int a, input int s, input logic [31:0] d);
    logic [31:0] w;
    int t;
    bit same;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'(a);
    req_size = 3'(s); req_wdata = d;
    #1;
    t = tgt_of(a);
    chk({core_we, dma_we, ctl_we} == {t == 1, t == 2, t == 3},
        (t == 0) ? "R4 unmapped write strobe" : "R7 R1 R2 R3 strobe select",
        {29'h0, core_we, dma_we, ctl_we}, {29'h0, t == 1, t == 2, t == 3});
    if (t == 1) chk(core_idx == 4'(a >> 2), "R1 core index", {28'h0, core_idx}, a >> 2);
    if (t == 2) chk(dma_idx == 3'((a - 'h40) >> 2), "R2 dma index", {29'h0, dma_idx},
                    (a - 'h40) >> 2);
    w = sh_word(a);
    for (int i = 0; i < s; i++)
      if ((a % 4) + i < 4) w[((a % 4) + i) * 8 +: 8] = d[i * 8 +: 8];
    sh_store(a, w);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R8 no response after write", {31'h0, rsp_valid}, 0);
    same = (m_ctl === sh_ctl);
    for (int i = 0; i < 16; i++) if (m_core[i] !== sh_core[i]) same = 1'b0;
    for (int i = 0; i < 8; i++)  if (m_dma[i] !== sh_dma[i]) same = 1'b0;
    chk(same, "R6 merged lanes / R4 no change", m_core[(a >> 2) & 15], w);
  endtask

  task automatic do_read(input int a, input int s);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 7'(a); req_size = 3'(s);
    e = sh_word(a) >> (8 * (a % 4));
    if (s < 4) e = e & ((32'h1 << (8 * s)) - 32'h1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R8 read response valid", {31'h0, rsp_valid}, 1);
    chk(rsp_rdata == e, (tgt_of(a) == 0) ? "R4 unmapped read zero" : "R5 R9 read shift mask",
        rsp_rdata, e);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_core[i] = '0; sh_core[i] = '0; end
    for (int i = 0; i < 8; i++)  begin m_dma[i] = '0;  sh_dma[i] = '0;  end
    m_ctl = '0; sh_ctl = '0;
    #12;
    chk(rsp_valid == 1'b0 && rsp_rdata == '0, "R8 reset state", rsp_rdata, 0);
    rst_n = 1'b1;
    // full-word preload of the whole window
    for (int a = 0; a < 128; a += 4)
      do_write(a, 4, 32'(a) * 32'h01030507 ^ 32'hc3a5_5a3c);
    // every offset, every size: reads
    for (int s = 1; s <= 4; s++)
      for (int a = 0; a < 128; a++) do_read(a, s);
    // every offset, every size: merged writes then readback
    for (int s = 1; s <= 4; s++)
      for (int a = 0; a < 128; a++) begin
        do_write(a, s, (32'(a) * 32'h9e3779b9) ^ (32'(s) << 28) ^ 32'h1357_9bdf);
        do_read(a & 'h7c, 4);
      end
    // idle cycle yields no response
    @(negedge clk); @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R8 idle no response", {31'h0, rsp_valid}, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule